// File: doc/BRIEF.md
# Ramp-Compare Converter Capture and Readout Engine

This block is the digital half of a bank of ramp-compare (Wilkinson) converters behind a 256-cell analog sampling array. One shared binary counter advances on a gated fast clock while an analog ramp rises. Every cell owns a comparator input and a storage register. The first change of a cell's comparator during the conversion window copies the running count into that cell's register. A cell whose comparator stays silent for the whole window receives the full-scale code, with an extra overcount bit set.

Once the window has closed, a single token walks through the cells one by one. The cell that holds the token places its stored value on a shared 12-bit bus, with the overcount bit on a side output. The bus is driven only while the read enable is high. When the token leaves the last cell, a one-cycle done pulse is raised and the engine becomes idle again.

A sequencer with five named states controls the engine:
- `ST_IDLE` goes to `ST_CONVERT` on a start request.
- `ST_CONVERT` goes to `ST_FLAG_LATE` on the enabled clock at which the last count of the window is reached.
- `ST_FLAG_LATE` always goes to `ST_HOLD` after one cycle.
- `ST_HOLD` goes to `ST_SCAN` on the first cycle with read enable high.
- `ST_SCAN` goes back to `ST_IDLE` on the read-enabled cycle at which the token sits on the last cell.

Top module: `ramp_adc_backend`

## Requirements
- R1: After reset the engine is idle. `rd_valid`, `rd_done` and `rd_over` are 0 and `rd_data` is 0, even when `read_en` is high.
- R2: A `conv_start` high in `ST_IDLE` does three things: it clears every capture flag, resets the counter to 0 and latches `short_sel`. A `conv_start` seen in any other state has no effect, and the stored values are kept.
- R3: During conversion the counter advances by one only on cycles with `clk_en` high. A comparator change first seen at a clock edge captures the count as it stands before that edge. That count equals the number of enabled cycles that follow the start edge and come before the change.
- R4: A cell captures on a comparator change in either direction. It captures only its first change per conversion. Later changes leave the stored value unchanged.
- R5: The window covers counts 0 to 4095 when `short_sel` is 0, and counts 0 to 1119 when it is 1. A change seen at the edge that ends the window still captures the last count.
- R6: A cell that did not capture during the window stores data 0xFFF with the overcount bit at 1. A captured cell has its overcount bit at 0.
- R7: The first cycle with `read_en` high after the window closes loads the token at cell 0. Each later cycle with `read_en` high moves the token up by one cell, so the cells appear on `rd_data` in index order 0 to 255.
- R8: `rd_valid` is 1 only while `read_en` is high and a token is present. Otherwise `rd_data` and `rd_over` are 0. With `read_en` low the token holds its position.
- R9: After cell 255 has been presented on a read-enabled cycle, `rd_done` is 1 for exactly one cycle. The token is removed and the engine returns to idle.
- R10: At most one cell holds the token at any time.
- R11: Comparator changes outside the conversion window do not alter the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast conversion and readout clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Start request; honoured only when idle |
| short_sel | input | 1 | Window select: 0 for 4096 counts, 1 for 1120 counts |
| clk_en | input | 1 | Counter clock enable, held high only during the window |
| read_en | input | 1 | Advances the token and enables the bus drivers |
| cmp_in | input | 256 | Per-cell comparator outputs |
| rd_data | output | 12 | Stored count of the cell holding the token |
| rd_over | output | 1 | Overcount bit of the cell holding the token |
| rd_valid | output | 1 | Bus carries a cell value this cycle |
| rd_done | output | 1 | One-cycle pulse after the last cell was read |

## Verification
The assertions assume that `read_en` is only raised for readout after the window has closed. They also assume that `clk_en` is a plain level and that the counter does not move while it is low. The stimulus raises `clk_en` only inside the conversion it drives, and it drops `read_en` only between two cell presentations. The stimulus changes the comparators just after a clock edge, so the count that a cell should capture follows directly from the number of enabled edges. Late changes, out-of-window changes and a misplaced start request are all placed where the sequencer is known to be in `ST_HOLD` or `ST_FLAG_LATE`.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CONVERT   = 3'd1,
        ST_FLAG_LATE = 3'd2,
        ST_HOLD      = 3'd3,
        ST_SCAN      = 3'd4
    } seq_state_t;

endpackage

// File: rtl/adc_shared_counter.sv
module adc_shared_counter #(
    parameter int CW        = 12,
    parameter int SHORT_LIM = 1120
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          short_sel,
    input  logic          advance,
    output logic [CW-1:0] cnt,
    output logic          at_last
);
    localparam logic [CW-1:0] LAST_FULL  = '1;
    localparam logic [CW-1:0] LAST_SHORT = CW'(SHORT_LIM - 1);

    logic short_q;

    // Window select is sampled once per conversion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_q <= 1'b0;
        end else if (clr) begin
            short_q <= short_sel;
        end
    end

    always_comb begin
        at_last = short_q ? (cnt == LAST_SHORT) : (cnt == LAST_FULL);
    end

    // Counter holds at its last value; the sequencer closes the window there
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (advance && !at_last) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_cell_bank.sv
module adc_cell_bank #(
    parameter int N  = 256,
    parameter int CW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic               fill,
    input  logic [CW-1:0]      cnt,
    input  logic [N-1:0]       cmp_in,
    output logic [N-1:0][CW:0] store
);
    localparam logic [CW:0] FULL_SCALE = {1'b1, {CW{1'b1}}};

    for (genvar g = 0; g < N; g++) begin : g_cell
        logic prev;
        logic taken;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev <= 1'b0;
            end else begin
                prev <= cmp_in[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                taken    <= 1'b0;
                store[g] <= '0;
            end else if (clr) begin
                taken    <= 1'b0;
            end else if (run && !taken && (cmp_in[g] != prev)) begin
                taken    <= 1'b1;
                store[g] <= {1'b0, cnt};
            end else if (fill && !taken) begin
                taken    <= 1'b1;
                store[g] <= FULL_SCALE;
            end
        end
    end

endmodule

// File: rtl/adc_token_chain.sv
module adc_token_chain #(
    parameter int N  = 256,
    parameter int CW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               read_en,
    input  logic [N-1:0][CW:0] store,
    output logic [N-1:0]       tok,
    output logic               tok_last,
    output logic [CW-1:0]      rd_data,
    output logic               rd_over,
    output logic               rd_valid,
    output logic               rd_done
);
    logic [CW:0] bus_or;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tok <= '0;
        end else if (load) begin
            tok <= {{(N-1){1'b0}}, 1'b1};
        end else if (read_en) begin
            tok <= tok << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_done <= 1'b0;
        end else begin
            rd_done <= read_en && tok[N-1];
        end
    end

    assign tok_last = tok[N-1];

    // Tri-state bus modelled as an AND-OR tree keyed by the one-hot token
    always_comb begin
        bus_or = '0;
        for (int i = 0; i < N; i++) begin
            bus_or = bus_or | ({(CW+1){tok[i]}} & store[i]);
        end
        rd_valid = read_en && (|tok);
        if (rd_valid) begin
            {rd_over, rd_data} = bus_or;
        end else begin
            {rd_over, rd_data} = '0;
        end
    end

endmodule

// File: rtl/adc_ctrl_fsm.sv
module adc_ctrl_fsm
    import ramp_adc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_start,
    input  logic       clk_en,
    input  logic       read_en,
    input  logic       at_last,
    input  logic       tok_last,
    output seq_state_t state,
    output logic       clr,
    output logic       run,
    output logic       fill,
    output logic       load
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      if (conv_start)            state <= ST_CONVERT;
                ST_CONVERT:   if (clk_en && at_last)     state <= ST_FLAG_LATE;
                ST_FLAG_LATE:                            state <= ST_HOLD;
                ST_HOLD:      if (read_en)               state <= ST_SCAN;
                ST_SCAN:      if (read_en && tok_last)   state <= ST_IDLE;
                default:                                 state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        clr  = 1'b0;
        run  = 1'b0;
        fill = 1'b0;
        load = 1'b0;
        unique case (state)
            ST_IDLE:      clr  = conv_start;
            ST_CONVERT:   run  = 1'b1;
            ST_FLAG_LATE: fill = 1'b1;
            ST_HOLD:      load = read_en;
            ST_SCAN:      ;
            default:      ;
        endcase
    end

endmodule

// File: rtl/ramp_adc_backend.sv
module ramp_adc_backend
    import ramp_adc_pkg::*;
#(
    parameter int N_CELLS   = 256,
    parameter int CNT_W     = 12,
    parameter int SHORT_LIM = 1120
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               conv_start,
    input  logic               short_sel,
    input  logic               clk_en,
    input  logic               read_en,
    input  logic [N_CELLS-1:0] cmp_in,
    output logic [CNT_W-1:0]   rd_data,
    output logic               rd_over,
    output logic               rd_valid,
    output logic               rd_done
);
    seq_state_t                     state;
    logic                           clr;
    logic                           run;
    logic                           fill;
    logic                           load;
    logic                           at_last;
    logic                           tok_last;
    logic [CNT_W-1:0]               cnt;
    logic [N_CELLS-1:0]             tok;
    logic [N_CELLS-1:0][CNT_W:0]    store;

    adc_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .clk_en     (clk_en),
        .read_en    (read_en),
        .at_last    (at_last),
        .tok_last   (tok_last),
        .state      (state),
        .clr        (clr),
        .run        (run),
        .fill       (fill),
        .load       (load)
    );

    adc_shared_counter #(.CW(CNT_W), .SHORT_LIM(SHORT_LIM)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .short_sel (short_sel),
        .advance   (run && clk_en),
        .cnt       (cnt),
        .at_last   (at_last)
    );

    adc_cell_bank #(.N(N_CELLS), .CW(CNT_W)) u_cells (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .run    (run),
        .fill   (fill),
        .cnt    (cnt),
        .cmp_in (cmp_in),
        .store  (store)
    );

    adc_token_chain #(.N(N_CELLS), .CW(CNT_W)) u_tok (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .read_en  (read_en),
        .store    (store),
        .tok      (tok),
        .tok_last (tok_last),
        .rd_data  (rd_data),
        .rd_over  (rd_over),
        .rd_valid (rd_valid),
        .rd_done  (rd_done)
    );

endmodule

// File: rtl/ramp_adc_backend_chk.sv
module ramp_adc_backend_chk #(
    parameter int N  = 256,
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          read_en,
    input logic          run,
    input logic [CW-1:0] cnt,
    input logic [N-1:0]  tok,
    input logic [CW-1:0] rd_data,
    input logic          rd_over,
    input logic          rd_valid,
    input logic          rd_done
);

    p_token_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tok));

    p_valid_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> read_en);

    p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0 && !rd_over));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> ($past(tok[N-1]) && $past(read_en)));

    p_count_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clk_en) |=> $stable(cnt));

    p_overcount_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_over) |-> (rd_data == '1));

endmodule

bind ramp_adc_backend ramp_adc_backend_chk #(.N(N_CELLS), .CW(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .read_en  (read_en),
    .run      (run),
    .cnt      (cnt),
    .tok      (tok),
    .rd_data  (rd_data),
    .rd_over  (rd_over),
    .rd_valid (rd_valid),
    .rd_done  (rd_done)
);

// File: tb/ramp_adc_backend_tb.sv
module ramp_adc_backend_tb;
    localparam int N  = 256;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_start = 1'b0;
    logic          short_sel = 1'b0;
    logic          clk_en = 1'b0;
    logic          read_en = 1'b0;
    logic [N-1:0]  cmp_in = '0;
    logic [CW-1:0] rd_data;
    logic          rd_over;
    logic          rd_valid;
    logic          rd_done;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  closed = 0;
    int  tgt   [N];
    int  tgt2  [N];
    int  exp_v [N];
    bit  exp_o [N];

    always #4 clk = ~clk;

    ramp_adc_backend u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .short_sel  (short_sel),
        .clk_en     (clk_en),
        .read_en    (read_en),
        .cmp_in     (cmp_in),
        .rd_data    (rd_data),
        .rd_over    (rd_over),
        .rd_valid   (rd_valid),
        .rd_done    (rd_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!closed) begin
            closed = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Drives one conversion; comparators change just after the edges
    task automatic run_conv(input bit short_m, input int gate);
        int  lim   = short_m ? 1120 : 4096;
        int  cnt_b = 0;
        int  cyc   = 0;
        bit  fresh = 1;
        bit  en;
        for (int i = 0; i < N; i++) begin
            if (tgt[i] >= 0 && tgt[i] < lim) begin
                exp_v[i] = tgt[i];
                exp_o[i] = 0;
            end else begin
                exp_v[i] = 4095;
                exp_o[i] = 1;
            end
        end
        @(posedge clk); #1;
        conv_start = 1; short_sel = short_m;
        @(posedge clk); #1;
        conv_start = 0;
        while (1) begin
            if (fresh) begin
                for (int i = 0; i < N; i++)
                    if (tgt[i] == cnt_b || tgt2[i] == cnt_b) cmp_in[i] = ~cmp_in[i];
            end
            fresh = 0;
            en = !(gate > 0 && (cyc % gate) == gate - 1);
            clk_en = en;
            cyc++;
            @(posedge clk); #1;
            if (en) begin
                if (cnt_b == lim - 1) break;
                cnt_b++;
                fresh = 1;
            end
        end
        clk_en = 0;
        // R11: toggling every comparator in the late-flag cycle and after
        cmp_in = ~cmp_in;
        @(posedge clk); #1;
        cmp_in = ~cmp_in;
        repeat (3) @(posedge clk);
    endtask

    task automatic run_read(input int pause_at, input string tag);
        @(negedge clk);
        read_en = 1;
        #1;
        chk(rd_valid == 0, "R7", {tag, " no data before token load"}, rd_valid, 0);
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            chk(rd_valid == 1, "R7", {tag, " valid during scan"}, rd_valid, 1);
            chk(rd_data == exp_v[i][CW-1:0], "R7", $sformatf("%s data cell %0d", tag, i),
                rd_data, exp_v[i]);
            chk(rd_over == exp_o[i], "R6", $sformatf("%s overcount cell %0d", tag, i),
                rd_over, exp_o[i]);
            chk(rd_done == 0, "R9", {tag, " no early done"}, rd_done, 0);
            if (i == pause_at) begin
                read_en = 0;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    chk(rd_valid == 0 && rd_data == 0, "R8", {tag, " bus quiet while paused"},
                        rd_data, 0);
                end
                read_en = 1;
                #1;
                chk(rd_data == exp_v[i][CW-1:0], "R8", {tag, " token held over pause"},
                    rd_data, exp_v[i]);
            end
        end
        @(negedge clk);
        chk(rd_done == 1, "R9", {tag, " done after last cell"}, rd_done, 1);
        chk(rd_valid == 0, "R9", {tag, " token removed"}, rd_valid, 0);
        @(negedge clk);
        chk(rd_done == 0, "R9", {tag, " done lasts one cycle"}, rd_done, 0);
        chk(rd_valid == 0, "R9", {tag, " idle after done"}, rd_valid, 0);
        read_en = 0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        read_en = 1;
        #1;
        chk(rd_valid == 0, "R1", "valid after reset", rd_valid, 0);
        chk(rd_done == 0, "R1", "done after reset", rd_done, 0);
        chk(rd_data == 0 && rd_over == 0, "R1", "bus after reset", rd_data, 0);
        @(negedge clk);
        chk(rd_valid == 0, "R8", "no token when idle", rd_valid, 0);
        read_en = 0;
    endtask

    // Full window, ungated clock, both polarities, late toggles, stray start
    task automatic test_full();
        for (int i = 0; i < N; i++) begin
            cmp_in[i] = i[0];
            tgt[i] = (i % 17 == 3) ? -1 : (i * 37 + 5) % 4096;
            if (i == 7) tgt[i] = 0;      // R3 first count
            if (i == 8) tgt[i] = 4095;   // R5 last count
            tgt2[i] = (i % 5 == 0 && tgt[i] >= 0 && tgt[i] + 3 < 4096) ? tgt[i] + 3 : -1;  // R4
        end
        run_conv(0, 0);
        // R2: a start request while holding results must be ignored
        @(negedge clk);
        conv_start = 1;
        @(negedge clk);
        conv_start = 0;
        run_read(100, "full");
    endtask

    // Short window with the clock enable gated one cycle in three
    task automatic test_short();
        for (int i = 0; i < N; i++) begin
            cmp_in[i] = i[1];
            tgt[i] = (i * 13 + 1) % 1300;
            if (i == 0) tgt[i] = 1119;   // R5 last short count
            if (i == 1) tgt[i] = 1120;   // R5 beyond short window
            tgt2[i] = (i % 7 == 0 && tgt[i] + 1 < 1120) ? tgt[i] + 1 : -1;
        end
        run_conv(1, 3);
        run_read(-1, "short");
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        test_reset();
        test_full();
        test_short();
        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule